// File: doc/BRIEF.md
# Multi-Core Translation Cache Shootdown Unit

This block keeps the address translation caches of a small cluster of cores consistent. Each core owns a fully associative unified translation cache and a small shadow translation cache. Both are held in registers inside the block. Each core also has a local write port for the unified entries and a lookup port that reports hits combinationally.

When a core writes a unified entry with its valid flag cleared, its own entry is cleared at the next edge and a shootdown request is raised. The request carries the virtual page tag that was written. A round-robin arbiter places one request per cycle on an internal message bus, which is visible at the ports. Every core other than the sender then clears each valid unified entry whose tag equals the message tag, whatever the owning process is. Each of those cores also empties its entire shadow cache.

Cleared entries are never refilled by the block: a later lookup simply misses. A lookup that coincides with the cycle in which a matching entry is being shot down already reports a miss.

Top module: `tlb_shootdown`

## Requirements
- R1: A synchronous active-high reset clears every unified and shadow valid bit and every pending request. In the first cycle after reset, busy is all zero, msg_valid is 0 and no lookup hits.
- R2: A unified write with the valid input at 1 installs tag and process ID at the given index from the next edge on. A shadow write does the same for a shadow slot. The lookup output of a core is 1 in the same cycle when any valid unified or shadow entry of that core has both tag and process ID equal to the lookup inputs.
- R3: Only a unified write with the valid input at 0 issues a shootdown. Its message tag is the tag written with it. Unified writes with the valid input at 1 and shadow writes never put a message on the bus.
- R4: busy of a core goes to 1 in the cycle after its invalidating write. It stays 1 up to and including the cycle in which its message is on the bus, and returns to 0 in the cycle after that.
- R5: At most one message is on the bus per cycle. When several requests are pending, the winner is the first pending core found searching upward (wrapping) from the core after the last winner. After reset the search starts at core 0.
- R6: During a message cycle, every core other than msg_src clears, at the closing edge, all valid unified entries whose tag equals msg_tag, independent of their process ID.
- R7: Every core other than msg_src empties all of its shadow slots at the closing edge of any message cycle, even when no shadow tag matches.
- R8: The unified and shadow contents of the core named by msg_src are not changed by its own message.
- R9: In a message cycle, a lookup at a receiving core does not hit on an entry whose tag equals msg_tag, even though the clear only lands at the closing edge.
- R10: If a local write to an entry or slot lands at the same edge as a remote clear of it, the written value is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | NCORE | Unified write strobe, bit c for core c |
| wr_idx | input | NCORE*IDX_W | Unified entry index, core c in bits [c*IDX_W +: IDX_W] |
| wr_valid | input | NCORE | Valid flag written; 0 requests a shootdown |
| wr_tag | input | NCORE*TAG_W | Virtual page tag written, core c in bits [c*TAG_W +: TAG_W] |
| wr_pid | input | NCORE*PID_W | Process ID written, core c in bits [c*PID_W +: PID_W] |
| sh_wr_en | input | NCORE | Shadow slot write strobe per core |
| sh_wr_idx | input | NCORE*SIDX_W | Shadow slot index per core |
| sh_wr_tag | input | NCORE*TAG_W | Shadow tag per core |
| sh_wr_pid | input | NCORE*PID_W | Shadow process ID per core |
| lk_tag | input | NCORE*TAG_W | Lookup tag per core |
| lk_pid | input | NCORE*PID_W | Lookup process ID per core |
| lk_hit | output | NCORE | Lookup hit per core |
| busy | output | NCORE | Shootdown of this core not yet applied |
| msg_valid | output | 1 | A shootdown message is applied this cycle |
| msg_src | output | CORE_W | Core that issued the current message |
| msg_tag | output | TAG_W | Tag carried by the current message |

## Verification
Two functions can fall in the same cycle: a lookup at a receiving core and the shootdown that removes the entry it would hit. A local write can also land on an entry at the same edge a remote clear hits it. The bench holds the lookup tags of all cores on the tag being shot down through the write cycle and the message cycle. It also issues a valid write to a matching entry of a receiver exactly in the message cycle. A behavioural model checks every lookup output, busy bit and message field each cycle: a lookup must miss from the message cycle on, and the newly written entry must survive the clear.

// File: rtl/tsd_pkg.sv
package tsd_pkg;
   localparam int DEF_NCORE = 4;
   localparam int DEF_NENT  = 16;
   localparam int DEF_NSHD  = 2;
   localparam int DEF_TAG_W = 22;
   localparam int DEF_PID_W = 8;

   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/tsd_rr_arb.sv
module tsd_rr_arb #(
   parameter int N    = 4,
   parameter int IW   = 2
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [N-1:0]  req,
   output logic          gnt_vld,
   output logic [IW-1:0] gnt_idx
);
   logic [IW-1:0] last_q;

   always_comb begin
      gnt_vld = 1'b0;
      gnt_idx = '0;
      for (int i = 0; i < N; i++) begin
         if (!gnt_vld && req[(int'(last_q) + 1 + i) % N]) begin
            gnt_vld = 1'b1;
            gnt_idx = IW'((int'(last_q) + 1 + i) % N);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst)          last_q <= IW'(N - 1);
      else if (gnt_vld) last_q <= gnt_idx;
   end
endmodule

// File: rtl/tsd_core_tlb.sv
module tsd_core_tlb #(
   parameter int NENT   = 16,
   parameter int NSHD   = 2,
   parameter int TAG_W  = 22,
   parameter int PID_W  = 8,
   parameter int IDX_W  = 4,
   parameter int SIDX_W = 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic              wr_valid,
   input  logic [TAG_W-1:0]  wr_tag,
   input  logic [PID_W-1:0]  wr_pid,
   input  logic              sh_wr_en,
   input  logic [SIDX_W-1:0] sh_wr_idx,
   input  logic [TAG_W-1:0]  sh_wr_tag,
   input  logic [PID_W-1:0]  sh_wr_pid,
   input  logic              kill_en,
   input  logic [TAG_W-1:0]  kill_tag,
   input  logic [TAG_W-1:0]  lk_tag,
   input  logic [PID_W-1:0]  lk_pid,
   output logic              lk_hit
);
   logic [NENT-1:0] u_hit;
   logic [NSHD-1:0] s_hit;

   for (genvar e = 0; e < NENT; e++) begin : g_ent
      logic             v_q;
      logic [TAG_W-1:0] tag_q;
      logic [PID_W-1:0] pid_q;
      logic             sel_w;
      logic             kill_w;

      assign sel_w  = wr_en && (wr_idx == IDX_W'(e));
      assign kill_w = kill_en && v_q && (tag_q == kill_tag);

      always_ff @(posedge clk) begin
         if (rst) begin
            v_q   <= 1'b0;
            tag_q <= '0;
            pid_q <= '0;
         end else if (sel_w) begin
            v_q   <= wr_valid;
            tag_q <= wr_tag;
            pid_q <= wr_pid;
         end else if (kill_w) begin
            v_q   <= 1'b0;
         end
      end

      assign u_hit[e] = v_q && !kill_w && (tag_q == lk_tag) && (pid_q == lk_pid);
   end

   for (genvar s = 0; s < NSHD; s++) begin : g_shd
      logic             v_q;
      logic [TAG_W-1:0] tag_q;
      logic [PID_W-1:0] pid_q;
      logic             sel_w;

      assign sel_w = sh_wr_en && (sh_wr_idx == SIDX_W'(s));

      always_ff @(posedge clk) begin
         if (rst) begin
            v_q   <= 1'b0;
            tag_q <= '0;
            pid_q <= '0;
         end else if (sel_w) begin
            v_q   <= 1'b1;
            tag_q <= sh_wr_tag;
            pid_q <= sh_wr_pid;
         end else if (kill_en) begin
            v_q   <= 1'b0;
         end
      end

      assign s_hit[s] = v_q && !kill_en && (tag_q == lk_tag) && (pid_q == lk_pid);
   end

   assign lk_hit = (|u_hit) || (|s_hit);
endmodule

// File: rtl/tlb_shootdown.sv
module tlb_shootdown
   import tsd_pkg::*;
#(
   parameter int NCORE  = DEF_NCORE,
   parameter int NENT   = DEF_NENT,
   parameter int NSHD   = DEF_NSHD,
   parameter int TAG_W  = DEF_TAG_W,
   parameter int PID_W  = DEF_PID_W,
   parameter int IDX_W  = idx_width(NENT),
   parameter int SIDX_W = idx_width(NSHD),
   parameter int CORE_W = idx_width(NCORE)
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic [NCORE-1:0]        wr_en,
   input  logic [NCORE*IDX_W-1:0]  wr_idx,
   input  logic [NCORE-1:0]        wr_valid,
   input  logic [NCORE*TAG_W-1:0]  wr_tag,
   input  logic [NCORE*PID_W-1:0]  wr_pid,
   input  logic [NCORE-1:0]        sh_wr_en,
   input  logic [NCORE*SIDX_W-1:0] sh_wr_idx,
   input  logic [NCORE*TAG_W-1:0]  sh_wr_tag,
   input  logic [NCORE*PID_W-1:0]  sh_wr_pid,
   input  logic [NCORE*TAG_W-1:0]  lk_tag,
   input  logic [NCORE*PID_W-1:0]  lk_pid,
   output logic [NCORE-1:0]        lk_hit,
   output logic [NCORE-1:0]        busy,
   output logic                    msg_valid,
   output logic [CORE_W-1:0]       msg_src,
   output logic [TAG_W-1:0]        msg_tag
);
   if (NCORE < 2)              begin : g_bad_ncore $error("NCORE must be at least 2"); end
   if (NENT < 1 || NSHD < 1)   begin : g_bad_depth $error("cache depths must be positive"); end
   if (IDX_W < idx_width(NENT)) begin : g_bad_idx  $error("IDX_W too narrow"); end
   if (SIDX_W < idx_width(NSHD)) begin : g_bad_sidx $error("SIDX_W too narrow"); end
   if (CORE_W < idx_width(NCORE)) begin : g_bad_cw $error("CORE_W too narrow"); end

   logic [NCORE-1:0] pend_q;
   logic [TAG_W-1:0] ptag_q [NCORE];
   logic             gnt_vld;
   logic [CORE_W-1:0] gnt_idx;

   tsd_rr_arb #(.N(NCORE), .IW(CORE_W)) u_arb (
      .clk     (clk),
      .rst     (rst),
      .req     (pend_q),
      .gnt_vld (gnt_vld),
      .gnt_idx (gnt_idx)
   );

   assign msg_valid = gnt_vld;
   assign msg_src   = gnt_idx;
   assign msg_tag   = gnt_vld ? ptag_q[gnt_idx] : '0;
   assign busy      = pend_q;

   for (genvar c = 0; c < NCORE; c++) begin : g_core
      logic req_w;
      logic kill_w;

      assign req_w  = wr_en[c] && !wr_valid[c];
      assign kill_w = gnt_vld && (gnt_idx != CORE_W'(c));

      always_ff @(posedge clk) begin
         if (rst) begin
            pend_q[c] <= 1'b0;
            ptag_q[c] <= '0;
         end else if (req_w) begin
            pend_q[c] <= 1'b1;
            ptag_q[c] <= wr_tag[c*TAG_W +: TAG_W];
         end else if (gnt_vld && gnt_idx == CORE_W'(c)) begin
            pend_q[c] <= 1'b0;
         end
      end

      tsd_core_tlb #(
         .NENT(NENT), .NSHD(NSHD), .TAG_W(TAG_W), .PID_W(PID_W),
         .IDX_W(IDX_W), .SIDX_W(SIDX_W)
      ) u_tlb (
         .clk       (clk),
         .rst       (rst),
         .wr_en     (wr_en[c]),
         .wr_idx    (wr_idx[c*IDX_W +: IDX_W]),
         .wr_valid  (wr_valid[c]),
         .wr_tag    (wr_tag[c*TAG_W +: TAG_W]),
         .wr_pid    (wr_pid[c*PID_W +: PID_W]),
         .sh_wr_en  (sh_wr_en[c]),
         .sh_wr_idx (sh_wr_idx[c*SIDX_W +: SIDX_W]),
         .sh_wr_tag (sh_wr_tag[c*TAG_W +: TAG_W]),
         .sh_wr_pid (sh_wr_pid[c*PID_W +: PID_W]),
         .kill_en   (kill_w),
         .kill_tag  (msg_tag),
         .lk_tag    (lk_tag[c*TAG_W +: TAG_W]),
         .lk_pid    (lk_pid[c*PID_W +: PID_W]),
         .lk_hit    (lk_hit[c])
      );
   end
endmodule

// File: rtl/tsd_checker.sv
module tsd_checker #(
   parameter int NCORE  = 4,
   parameter int TAG_W  = 22,
   parameter int CORE_W = 2
) (
   input logic                   clk,
   input logic                   rst,
   input logic [NCORE-1:0]       wr_en,
   input logic [NCORE-1:0]       wr_valid,
   input logic [NCORE*TAG_W-1:0] lk_tag,
   input logic [NCORE-1:0]       lk_hit,
   input logic [NCORE-1:0]       busy,
   input logic                   msg_valid,
   input logic [CORE_W-1:0]      msg_src,
   input logic [TAG_W-1:0]       msg_tag
);
   AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (busy == '0 && !msg_valid && lk_hit == '0)); // R1

   AST_MSG_FROM_BUSY: assert property (@(posedge clk) disable iff (rst)
      msg_valid |-> busy[msg_src]); // R4

   for (genvar c = 0; c < NCORE; c++) begin : g_chk
      logic [7:0] wait_q;
      always_ff @(posedge clk) begin
         if (rst || !busy[c]) wait_q <= '0;
         else if (wait_q != 8'hFF) wait_q <= wait_q + 8'd1;
      end

      AST_REQ_RAISES_BUSY: assert property (@(posedge clk) disable iff (rst)
         (wr_en[c] && !wr_valid[c]) |=> busy[c]); // R4

      AST_GRANT_DROPS_BUSY: assert property (@(posedge clk) disable iff (rst)
         (msg_valid && msg_src == CORE_W'(c) && !(wr_en[c] && !wr_valid[c])) |=> !busy[c]); // R4

      AST_BOUNDED_WAIT: assert property (@(posedge clk) disable iff (rst)
         busy[c] |-> (int'(wait_q) < NCORE)); // R5

      AST_SAME_CYCLE_MISS: assert property (@(posedge clk) disable iff (rst)
         (msg_valid && msg_src != CORE_W'(c) && lk_tag[c*TAG_W +: TAG_W] == msg_tag)
         |-> !lk_hit[c]); // R9
   end
endmodule

bind tlb_shootdown tsd_checker #(.NCORE(NCORE), .TAG_W(TAG_W), .CORE_W(CORE_W)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .wr_en     (wr_en),
   .wr_valid  (wr_valid),
   .lk_tag    (lk_tag),
   .lk_hit    (lk_hit),
   .busy      (busy),
   .msg_valid (msg_valid),
   .msg_src   (msg_src),
   .msg_tag   (msg_tag)
);

// File: tb/tb_tlb_shootdown.sv
module tb_tlb_shootdown;
   localparam int NC = 4, NE = 16, NS = 2, TW = 22, PW = 8, IW = 4, SW = 1, CW = 2;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #2 clk = ~clk;

   logic [NC-1:0]    wr_en, wr_valid, sh_wr_en;
   logic [NC*IW-1:0] wr_idx;
   logic [NC*TW-1:0] wr_tag, sh_wr_tag, lk_tag;
   logic [NC*PW-1:0] wr_pid, sh_wr_pid, lk_pid;
   logic [NC*SW-1:0] sh_wr_idx;
   logic [NC-1:0]    lk_hit, busy;
   logic             msg_valid;
   logic [CW-1:0]    msg_src;
   logic [TW-1:0]    msg_tag;

   tlb_shootdown dut (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_valid(wr_valid),
      .wr_tag(wr_tag), .wr_pid(wr_pid), .sh_wr_en(sh_wr_en), .sh_wr_idx(sh_wr_idx),
      .sh_wr_tag(sh_wr_tag), .sh_wr_pid(sh_wr_pid), .lk_tag(lk_tag), .lk_pid(lk_pid),
      .lk_hit(lk_hit), .busy(busy), .msg_valid(msg_valid), .msg_src(msg_src), .msg_tag(msg_tag)
   );

   int nchk = 0, nfail = 0;
   bit done = 0;
   string phase = "R2";

   bit mv [NC][NE]; int mt [NC][NE]; int mp [NC][NE];
   bit sv [NC][NS]; int st [NC][NS]; int sp [NC][NS];
   bit mpend [NC]; int mptag [NC];
   int rr_last = NC - 1;
   int cur_g = -1;

   task automatic chk(bit ok, string req, string what, int act, int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s %s act=%0d exp=%0d t=%0t", req, what, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      for (int c = 0; c < NC; c++) begin
         for (int e = 0; e < NE; e++) mv[c][e] = 0;
         for (int s = 0; s < NS; s++) sv[c][s] = 0;
         mpend[c] = 0;
      end
      rr_last = NC - 1;
   endtask

   task automatic compare();
      cur_g = -1;
      for (int i = 0; i < NC; i++)
         if (cur_g < 0 && mpend[(rr_last + 1 + i) % NC]) cur_g = (rr_last + 1 + i) % NC;
      chk(msg_valid == (cur_g >= 0), (cur_g >= 0) ? "R5" : "R3", "msg_valid", int'(msg_valid), int'(cur_g >= 0));
      if (cur_g >= 0) begin
         chk(int'(msg_src) == cur_g, "R5", "msg_src", int'(msg_src), cur_g);
         chk(int'(msg_tag) == mptag[cur_g], "R3", "msg_tag", int'(msg_tag), mptag[cur_g]);
      end
      for (int c = 0; c < NC; c++) begin
         bit recv, hit;
         int lt, lp;
         recv = (cur_g >= 0) && (c != cur_g);
         lt = int'(lk_tag[c*TW +: TW]);
         lp = int'(lk_pid[c*PW +: PW]);
         hit = 0;
         for (int e = 0; e < NE; e++)
            if (mv[c][e] && !(recv && mt[c][e] == mptag[cur_g]) && mt[c][e] == lt && mp[c][e] == lp) hit = 1;
         for (int s = 0; s < NS; s++)
            if (sv[c][s] && !recv && st[c][s] == lt && sp[c][s] == lp) hit = 1;
         chk(lk_hit[c] == hit, phase, $sformatf("lk_hit[%0d]", c), int'(lk_hit[c]), int'(hit));
         chk(busy[c] == mpend[c], "R4", $sformatf("busy[%0d]", c), int'(busy[c]), int'(mpend[c]));
      end
   endtask

   task automatic model_update();
      for (int c = 0; c < NC; c++) begin
         if (cur_g >= 0 && c != cur_g) begin
            for (int e = 0; e < NE; e++) if (mv[c][e] && mt[c][e] == mptag[cur_g]) mv[c][e] = 0;
            for (int s = 0; s < NS; s++) sv[c][s] = 0;
         end
      end
      for (int c = 0; c < NC; c++) begin
         if (wr_en[c]) begin
            int ix;
            ix = int'(wr_idx[c*IW +: IW]);
            mv[c][ix] = wr_valid[c];
            mt[c][ix] = int'(wr_tag[c*TW +: TW]);
            mp[c][ix] = int'(wr_pid[c*PW +: PW]);
         end
         if (sh_wr_en[c]) begin
            int sx;
            sx = int'(sh_wr_idx[c*SW +: SW]);
            sv[c][sx] = 1;
            st[c][sx] = int'(sh_wr_tag[c*TW +: TW]);
            sp[c][sx] = int'(sh_wr_pid[c*PW +: PW]);
         end
      end
      for (int c = 0; c < NC; c++) begin
         if (wr_en[c] && !wr_valid[c]) begin
            mpend[c] = 1;
            mptag[c] = int'(wr_tag[c*TW +: TW]);
         end else if (cur_g == c) mpend[c] = 0;
      end
      if (cur_g >= 0) rr_last = cur_g;
   endtask

   task automatic tick();
      #1;
      if (!rst) compare();
      @(posedge clk);
      if (rst) model_reset(); else model_update();
      @(negedge clk);
      wr_en = '0; sh_wr_en = '0;
   endtask

   task automatic uwr(int c, int ix, bit v, int tag, int pid);
      wr_en[c] = 1'b1; wr_valid[c] = v;
      wr_idx[c*IW +: IW] = IW'(ix);
      wr_tag[c*TW +: TW] = TW'(tag);
      wr_pid[c*PW +: PW] = PW'(pid);
   endtask

   task automatic swr(int c, int ix, int tag, int pid);
      sh_wr_en[c] = 1'b1;
      sh_wr_idx[c*SW +: SW] = SW'(ix);
      sh_wr_tag[c*TW +: TW] = TW'(tag);
      sh_wr_pid[c*PW +: PW] = PW'(pid);
   endtask

   task automatic lk_all(int tag, int pid);
      for (int c = 0; c < NC; c++) begin
         lk_tag[c*TW +: TW] = TW'(tag);
         lk_pid[c*PW +: PW] = PW'(pid);
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         nfail++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
         $finish;
      end
   end

   initial begin
      wr_en = '0; wr_valid = '0; wr_idx = '0; wr_tag = '0; wr_pid = '0;
      sh_wr_en = '0; sh_wr_idx = '0; sh_wr_tag = '0; sh_wr_pid = '0;
      lk_tag = '0; lk_pid = '0;
      @(negedge clk);
      rst = 1'b1;
      repeat (3) tick();
      rst = 1'b0;
      // R1: reset state
      phase = "R1";
      lk_all(0, 0);
      #1;
      chk(busy == '0, "R1", "busy after reset", int'(busy), 0);
      chk(!msg_valid, "R1", "msg_valid after reset", int'(msg_valid), 0);
      chk(lk_hit == '0, "R1", "lk_hit after reset", int'(lk_hit), 0);
      tick();

      // R2: fill all caches, then sweep lookups
      phase = "R2";
      for (int e = 0; e < NE; e++) begin
         for (int c = 0; c < NC; c++) uwr(c, e, 1'b1, 100 + (e % 4), e);
         tick();
      end
      for (int c = 0; c < NC; c++) swr(c, 0, 200, 60);
      tick();
      for (int c = 0; c < NC; c++) swr(c, 1, 201, 61);
      tick();
      for (int e = 0; e < NE; e++) begin lk_all(100 + (e % 4), e); tick(); end
      lk_all(200, 60); tick();
      lk_all(201, 61); tick();
      lk_all(100, 5); tick();

      // R3: a valid rewrite and a shadow write issue no message
      phase = "R3";
      uwr(1, 3, 1'b1, 103, 3); swr(2, 0, 200, 60);
      lk_all(103, 3);
      repeat (3) tick();

      // R9: lookups held on the shot-down tag through write and message cycles
      phase = "R9";
      lk_all(100, 4);
      uwr(0, 0, 1'b0, 100, 0);
      repeat (3) tick();
      // R6: other pids with the same tag are gone on receivers
      phase = "R6";
      lk_all(100, 8);  tick();
      lk_all(100, 12); tick();
      lk_all(101, 5);  tick();
      // R8: source core keeps its entries
      phase = "R8";
      lk_all(100, 12); tick();
      // R7: shadows emptied on receivers only
      phase = "R7";
      lk_all(200, 60); tick();
      lk_all(201, 61); tick();

      // R5: three simultaneous requests, then two more with wraparound
      phase = "R5";
      uwr(1, 1, 1'b0, 101, 0); uwr(2, 2, 1'b0, 102, 0); uwr(3, 3, 1'b0, 103, 0);
      lk_all(102, 6);
      repeat (6) tick();
      uwr(0, 6, 1'b0, 102, 0); uwr(2, 7, 1'b0, 103, 0);
      lk_all(103, 7);
      repeat (5) tick();
      uwr(3, 11, 1'b0, 103, 0); uwr(1, 10, 1'b0, 102, 0);
      repeat (5) tick();

      // R7: flush with a tag that matches nothing
      phase = "R7";
      for (int c = 0; c < NC; c++) swr(c, 0, 300, 70);
      tick();
      lk_all(300, 70);
      uwr(3, 15, 1'b0, 999, 0);
      repeat (4) tick();

      // R10: receiver writes the matching entry in the message cycle
      phase = "R10";
      for (int c = 0; c < NC; c++) uwr(c, 5, 1'b1, 101, 77);
      tick();
      lk_all(101, 77);
      uwr(0, 9, 1'b0, 101, 0);
      tick();
      uwr(2, 5, 1'b1, 101, 78);
      tick();
      lk_all(101, 78); repeat (2) tick();
      lk_all(101, 77); repeat (2) tick();

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end
endmodule